// File: doc/BRIEF.md
# Transmit FIFO Threshold Controller

This block watches a byte-wide transmit FIFO and makes two decisions about it. It tells the bus DMA engine when enough space is free to refill the FIFO. It also tells the MAC side when a frame has enough bytes stored to start transmission. A single occupancy count covers the whole FIFO, from the bus-side write port to the MAC-side read port. The FIFO storage itself is outside this block. The block only sees the write and read strobes and the end-of-frame markers on both sides.

Two 2-bit configuration fields set the thresholds. The start field selects a byte threshold, or a mode that holds transmission until a whole frame is stored. The watermark field selects how much free space must exist before a refill is requested. Both fields can only be changed while the controller is stopped or suspended. The start strobe is issued once per frame. It is armed again only after the MAC side has read the last byte of the frame that was started.

Top module: `txf_thresh_ctrl`

## Requirements
- R1: After a synchronous reset, start_sel reads 2'b01, wm_sel reads 2'b00, and tx_start is 0.
- R2: A configuration write (cfg_we high at a clock edge) updates start_sel and wm_sel only if halted is high at that edge. When halted is low, the write is ignored and both fields keep their values.
- R3: A write strobe at an edge where the FIFO holds DEPTH bytes is dropped. A read strobe at an edge where the FIFO is empty is dropped. Neither one changes the occupancy.
- R4: dma_req is high exactly when chk_pt is high and the free space (DEPTH minus occupancy) is at least the watermark. The watermark is selected by wm_sel: 00 gives 16 bytes, 01 gives 64, 10 gives 108, and 11 behaves like 00 (16).
- R5: In byte mode, start_sel 00 gives 20 bytes, 01 gives 64, and 10 gives 128. While the controller is armed, tx_start goes high in the cycle after any clock edge at which the occupancy held before that edge is at least the threshold. It also goes high the same way if a frame end is stored or the FIFO is full at that edge.
- R6: With start_sel 11 (full-packet mode), tx_start does not fire on byte count alone. It fires in the cycle after the first edge at which a stored frame end is present in the FIFO.
- R7: In full-packet mode, if the FIFO reaches DEPTH bytes before any frame end is stored, tx_start fires anyway.
- R8: After tx_start fires, no further tx_start occurs until a read with rd_eop is accepted. From the cycle after that read, the controller is armed again.
- R9: tx_start is a single-cycle pulse.
- R10: Raising or lowering halted without a configuration write leaves both fields and the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted | input | 1 | Stop or suspend condition; enables configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start_wr | input | 2 | Start field value to write |
| cfg_wm_wr | input | 2 | Watermark field value to write |
| wr_en | input | 1 | Bus side writes one byte into the FIFO |
| wr_eop | input | 1 | The byte being written ends a frame |
| rd_en | input | 1 | MAC side reads one byte from the FIFO |
| rd_eop | input | 1 | The byte being read ends a frame |
| chk_pt | input | 1 | Sequencer is at its FIFO check point |
| dma_req | output | 1 | Refill request to the bus DMA |
| tx_start | output | 1 | One-cycle strobe: the MAC side may start sending |
| start_sel | output | 2 | Current start field |
| wm_sel | output | 2 | Current watermark field |

## Verification
The bench targets these corner cases:
- A write attempted while the controller is running. A design that lets it through would move the thresholds in the middle of a frame.
- Writes pushed past a full FIFO and reads from an empty one. A design that does not guard the count would wrap the occupancy, and dma_req would then claim a large amount of free space.
- Full-packet mode filled to capacity with no frame end. A design without the full escape would never raise tx_start and would deadlock.
- Bytes of the next frame arriving before the current frame has drained. A design that fired on occupancy without the re-arm rule would start a frame twice.
- The reserved watermark code, and the free-space boundary at exactly the watermark and one byte below it. Off-by-one comparisons show up at that boundary.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int THR_W = 8;

    localparam logic [1:0] START_RST = 2'b01;
    localparam logic [1:0] WM_RST    = 2'b00;

    typedef enum logic [1:0] {
        SP_B20  = 2'b00,
        SP_B64  = 2'b01,
        SP_B128 = 2'b10,
        SP_FULL = 2'b11
    } start_mode_e;

    typedef struct packed {
        logic [1:0] start_sel;
        logic [1:0] wm_sel;
    } txf_cfg_t;

    function automatic logic [THR_W-1:0] start_bytes(input logic [1:0] sel);
        case (sel)
            SP_B20:  return THR_W'(20);
            SP_B64:  return THR_W'(64);
            SP_B128: return THR_W'(128);
            default: return THR_W'(0);
        endcase
    endfunction

    function automatic logic [THR_W-1:0] wm_bytes(input logic [1:0] sel);
        case (sel)
            2'b01:   return THR_W'(64);
            2'b10:   return THR_W'(108);
            default: return THR_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/txf_cfg_regs.sv
module txf_cfg_regs
    import txf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     halted,
    input  logic     cfg_we,
    input  txf_cfg_t cfg_wdata,
    output txf_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.start_sel <= START_RST;
            cfg_q.wm_sel    <= WM_RST;
        end else if (cfg_we && halted) begin
            cfg_q <= cfg_wdata;
        end
    end

    assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !halted) |=> $stable(cfg_q));

    assert_halt_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/txf_occ_track.sv
module txf_occ_track #(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_eop,
    input  logic             rd_en,
    input  logic             rd_eop,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] eop_cnt,
    output logic             rd_eop_acc
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic wr_acc;
    logic rd_acc;
    logic eop_inc;
    logic eop_dec;

    always_comb begin
        wr_acc     = wr_en && (occ != FULL_LVL);
        rd_acc     = rd_en && (occ != '0);
        eop_inc    = wr_acc && wr_eop;
        eop_dec    = rd_acc && rd_eop && (eop_cnt != '0);
        rd_eop_acc = rd_acc && rd_eop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ     <= '0;
            eop_cnt <= '0;
        end else begin
            case ({wr_acc, rd_acc})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            case ({eop_inc, eop_dec})
                2'b10:   eop_cnt <= eop_cnt + 1'b1;
                2'b01:   eop_cnt <= eop_cnt - 1'b1;
                default: eop_cnt <= eop_cnt;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_LVL && wr_en && !rd_en) |=> (occ == FULL_LVL));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && rd_en && !wr_en) |=> (occ == '0));

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_LVL);

endmodule

// File: rtl/txf_start_seq.sv
module txf_start_seq
    import txf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       start_sel,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] eop_cnt,
    input  logic             rd_eop_acc,
    output logic             tx_start
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic armed;
    logic ready;
    logic fire;

    always_comb begin
        ready = (eop_cnt != '0) || (occ == FULL_LVL);
        if (start_mode_e'(start_sel) != SP_FULL)
            ready = ready || (occ >= CNT_W'(start_bytes(start_sel)));
        fire = armed && ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b1;
            tx_start <= 1'b0;
        end else begin
            tx_start <= fire;
            if (fire)
                armed <= 1'b0;
            else if (rd_eop_acc)
                armed <= 1'b1;
        end
    end

    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    assert_full_pkt_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_start && $past(start_sel) == 2'b11) |->
            ($past(eop_cnt) != '0 || $past(occ) == FULL_LVL));

    assert_once_per_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !rd_eop_acc) |=> !tx_start);

endmodule

// File: rtl/txf_thresh_ctrl.sv
module txf_thresh_ctrl
    import txf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halted,
    input  logic       cfg_we,
    input  logic [1:0] cfg_start_wr,
    input  logic [1:0] cfg_wm_wr,
    input  logic       wr_en,
    input  logic       wr_eop,
    input  logic       rd_en,
    input  logic       rd_eop,
    input  logic       chk_pt,
    output logic       dma_req,
    output logic       tx_start,
    output logic [1:0] start_sel,
    output logic [1:0] wm_sel
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    txf_cfg_t         cfg_wdata;
    txf_cfg_t         cfg_q;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] eop_cnt;
    logic [CNT_W-1:0] free_cnt;
    logic             rd_eop_acc;

    assign cfg_wdata.start_sel = cfg_start_wr;
    assign cfg_wdata.wm_sel    = cfg_wm_wr;

    txf_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .halted    (halted),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    txf_occ_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_eop     (wr_eop),
        .rd_en      (rd_en),
        .rd_eop     (rd_eop),
        .occ        (occ),
        .eop_cnt    (eop_cnt),
        .rd_eop_acc (rd_eop_acc)
    );

    txf_start_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_sel  (cfg_q.start_sel),
        .occ        (occ),
        .eop_cnt    (eop_cnt),
        .rd_eop_acc (rd_eop_acc),
        .tx_start   (tx_start)
    );

    always_comb begin
        free_cnt = CNT_W'(DEPTH) - occ;
        dma_req  = chk_pt && (free_cnt >= CNT_W'(wm_bytes(cfg_q.wm_sel)));
    end

    assign start_sel = cfg_q.start_sel;
    assign wm_sel    = cfg_q.wm_sel;

    assert_dma_gated_R4: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> chk_pt);

    assert_dma_full_R4: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) |-> !dma_req);

endmodule

// File: tb/txf_thresh_ctrl_tb_top.sv
module txf_thresh_ctrl_tb_top;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halted = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_start_wr = 2'b00;
    logic [1:0] cfg_wm_wr = 2'b00;
    logic       wr_en = 1'b0;
    logic       wr_eop = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_eop = 1'b0;
    logic       chk_pt = 1'b0;
    logic       dma_req;
    logic       tx_start;
    logic [1:0] start_sel;
    logic [1:0] wm_sel;

    int n_checks = 0;
    int n_errors = 0;
    int pulses = 0;
    bit model_on = 1'b0;
    bit prev_start = 1'b0;

    int m_occ = 0;
    int m_eop = 0;
    int m_ss = 1;
    int m_wm = 0;
    bit m_armed = 1'b1;
    bit m_start = 1'b0;

    always #5 clk = ~clk;

    txf_thresh_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .halted       (halted),
        .cfg_we       (cfg_we),
        .cfg_start_wr (cfg_start_wr),
        .cfg_wm_wr    (cfg_wm_wr),
        .wr_en        (wr_en),
        .wr_eop       (wr_eop),
        .rd_en        (rd_en),
        .rd_eop       (rd_eop),
        .chk_pt       (chk_pt),
        .dma_req      (dma_req),
        .tx_start     (tx_start),
        .start_sel    (start_sel),
        .wm_sel       (wm_sel)
    );

    function automatic int wm_of(input int s);
        if (s == 1) return 64;
        if (s == 2) return 108;
        return 16;
    endfunction

    function automatic int sp_of(input int s);
        if (s == 0) return 20;
        if (s == 1) return 64;
        if (s == 2) return 128;
        return DEPTH + 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        bit wa, ra, fire, rdy;
        model_on = 1'b1;
        if (rst) begin
            m_occ = 0; m_eop = 0; m_ss = 1; m_wm = 0; m_armed = 1; m_start = 0;
        end else begin
            wa = wr_en && (m_occ != DEPTH);
            ra = rd_en && (m_occ != 0);
            rdy = (m_eop > 0) || (m_occ == DEPTH) || (m_occ >= sp_of(m_ss));
            fire = m_armed && rdy;
            m_start = fire;
            if (fire) m_armed = 0;
            else if (ra && rd_eop) m_armed = 1;
            if (cfg_we && halted) begin
                m_ss = int'(cfg_start_wr);
                m_wm = int'(cfg_wm_wr);
            end
            if (wa && wr_eop) m_eop++;
            if (ra && rd_eop && m_eop > 0) m_eop--;
            m_occ = m_occ + int'(wa) - int'(ra);
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check(dma_req == (chk_pt && (DEPTH - m_occ) >= wm_of(m_wm)), "R4 dma_req",
                  int'(dma_req), int'(chk_pt && (DEPTH - m_occ) >= wm_of(m_wm)));
            check(tx_start == m_start, "R5 tx_start", int'(tx_start), int'(m_start));
            check(int'(start_sel) == m_ss, "R2 start_sel", int'(start_sel), m_ss);
            check(int'(wm_sel) == m_wm, "R2 wm_sel", int'(wm_sel), m_wm);
            check(!(prev_start && tx_start), "R9 pulse width", int'(tx_start), 0);
            prev_start = tx_start;
            if (tx_start) pulses++;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit w, input bit we, input bit r, input bit re, input bit ch);
        wr_en = w; wr_eop = we; rd_en = r; rd_eop = re; chk_pt = ch;
        step();
        wr_en = 0; wr_eop = 0; rd_en = 0; rd_eop = 0;
    endtask

    task automatic write_n(input int n, input bit last_eop);
        for (int i = 0; i < n; i++) drive(1'b1, last_eop && (i == n - 1), 1'b0, 1'b0, 1'b1);
    endtask

    task automatic read_n(input int n, input bit last_eop);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b1, last_eop && (i == n - 1), 1'b1);
    endtask

    task automatic set_cfg(input logic [1:0] ss, input logic [1:0] wm, input bit h);
        halted = h; cfg_start_wr = ss; cfg_wm_wr = wm; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0; halted = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        int base;
        step(); step();
        rst = 1'b0;
        check(start_sel == 2'b01, "R1 start reset", int'(start_sel), 1);
        check(wm_sel == 2'b00, "R1 wm reset", int'(wm_sel), 0);
        check(tx_start == 1'b0, "R1 tx_start reset", int'(tx_start), 0);

        // R2: write while running is ignored
        set_cfg(2'b11, 2'b10, 1'b0);
        check(start_sel == 2'b01, "R2 ignored start", int'(start_sel), 1);
        check(wm_sel == 2'b00, "R2 ignored wm", int'(wm_sel), 0);
        set_cfg(2'b00, 2'b01, 1'b1);
        check(start_sel == 2'b00, "R2 accepted start", int'(start_sel), 0);
        check(wm_sel == 2'b01, "R2 accepted wm", int'(wm_sel), 1);

        // R10: halted toggle alone changes nothing
        halted = 1'b1; idle(3); halted = 1'b0; idle(2);
        check(start_sel == 2'b00 && wm_sel == 2'b01, "R10 halt toggle",
              int'({start_sel, wm_sel}), 1);

        // R5 byte threshold 20, then R8 re-arm
        pulses = 0;
        write_n(30, 1'b1); idle(3);
        check(pulses == 1, "R5 start at 20 bytes", pulses, 1);
        write_n(5, 1'b0); idle(3);
        check(pulses == 1, "R8 no restart before drain", pulses, 1);
        read_n(30, 1'b1); idle(3);
        check(pulses == 1, "R8 re-armed below threshold", pulses, 1);
        write_n(15, 1'b0); idle(3);
        check(pulses == 2, "R8 second frame start", pulses, 2);
        read_n(20, 1'b1); idle(2);

        // R6 full packet mode with frame end
        set_cfg(2'b11, 2'b10, 1'b1);
        base = pulses;
        write_n(100, 1'b0); idle(3);
        check(pulses == base, "R6 no start on count", pulses, base);
        write_n(1, 1'b1); idle(3);
        check(pulses == base + 1, "R6 start on frame end", pulses, base + 1);
        read_n(101, 1'b1); idle(2);

        // R7 full escape, R3 overflow
        base = pulses;
        write_n(260, 1'b0); idle(3);
        check(pulses == base + 1, "R7 start on full", pulses, base + 1);
        check(dma_req == 1'b0, "R3 full no dma", int'(dma_req), 0);
        read_n(256, 1'b1);
        read_n(3, 1'b0); idle(2);
        check(dma_req == 1'b1, "R3 empty after underflow attempt", int'(dma_req), 1);

        // R5 threshold 128, R4 reserved watermark boundary
        set_cfg(2'b10, 2'b11, 1'b1);
        base = pulses;
        write_n(127, 1'b0); idle(3);
        check(pulses == base, "R5 below 128", pulses, base);
        write_n(1, 1'b0); idle(3);
        check(pulses == base + 1, "R5 at 128", pulses, base + 1);
        write_n(112, 1'b0); idle(1);
        check(dma_req == 1'b1, "R4 free 16 with code 11", int'(dma_req), 1);
        write_n(1, 1'b0); idle(1);
        check(dma_req == 1'b0, "R4 free 15 with code 11", int'(dma_req), 0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(dma_req == 1'b0, "R4 gated by chk_pt", int'(dma_req), 0);
        read_n(241, 1'b1); idle(3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule